// File: doc/BRIEF.md
# Serial Receiver with Address-Frame Filtering

This block receives asynchronous serial frames for a node on a shared multi-drop line. An external divider supplies a one-cycle oversampling strobe. The receiver uses 16 strobes per bit in normal mode and 8 in double-speed mode. It votes three samples at the centre of each bit and assembles frames of 5 to 9 data bits, LSB first. A frame may carry an optional even or odd parity bit. Each accepted frame goes into a two-entry buffer together with its framing and parity flags.

Each frame carries an address/data marker. For 5 to 8 data bits the marker is the level of the first stop bit. For 9 data bits it is the ninth data bit. A marker of 1 means an address frame and a marker of 0 means a data frame. While the filter control is high, data frames are dropped before they reach the buffer and address frames still pass. Software watches the address frames. When one matches its own node, it lowers the filter control, and the frames that follow reach it.

All frame settings are sampled when a start bit is detected, so a change in the middle of a frame applies only from the next frame.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset `rx_valid` and `rx_ovr` are 0.
- R2: In normal mode (`dbl_speed`=0) a bit lasts 16 `os_tick` strobes. Data bits arrive LSB first and appear right-aligned on `rx_data`, with unused upper bits at 0.
- R3: In double-speed mode (`dbl_speed`=1) a bit lasts 8 `os_tick` strobes and frames are received correctly at that rate.
- R4: `len_sel` selects the data length: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, and 4 to 7 give 9 bits.
- R5: `par_mode` selects parity: 2 is even, 3 is odd, and 0 or 1 means no parity bit. A parity mismatch sets `rx_perr` for that entry.
- R6: A first stop bit sampled low sets `rx_ferr` for that entry. Only one stop bit is examined.
- R7: With `filt_en` low every frame is written to the buffer.
- R8: With `filt_en` high a frame with marker 0 is discarded. For 5 to 8 bits the marker is the first stop bit, so a frame with a framing error counts as a data frame.
- R9: For 9-bit frames the marker is the ninth bit, and it is readable as `rx_data[8]`.
- R10: A frame with marker 1 is accepted even while `filt_en` is high.
- R11: The buffer holds two frames in arrival order, and the head stays stable until `rd_en` pops it. A frame that would be accepted while the buffer is full is discarded and sets `rx_ovr`. The flag clears on the next pop.
- R12: `filt_en`, `len_sel`, `par_mode` and `dbl_speed` are sampled at start-bit detection. A change during a frame does not affect that frame.
- R13: Each bit is the majority of three centre samples, so a one-sample glitch does not corrupt it. A low pulse that is high again at start-bit mid-time is ignored as a false start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle oversampling strobe |
| dbl_speed | input | 1 | 1 = 8 strobes per bit, 0 = 16 |
| len_sel | input | 3 | Data length code |
| par_mode | input | 2 | Parity mode code |
| filt_en | input | 1 | Drop data-marked frames when high |
| rd_en | input | 1 | Pop the buffer head |
| rx_valid | output | 1 | Buffer not empty |
| rx_data | output | 9 | Head frame data, bit 8 = ninth bit |
| rx_ferr | output | 1 | Head frame stop bit was low |
| rx_perr | output | 1 | Head frame parity mismatch |
| rx_ovr | output | 1 | A frame was lost to a full buffer |

## Verification
The assertions take for granted a few things about the inputs:
- `os_tick` is a single-cycle strobe.
- `rd_en` is raised only while `rx_valid` is high.
- No pop coincides with a frame completing into a full buffer.

The stimulus keeps within these limits. It changes the line only at whole bit periods built from a fixed strobe spacing, and pulses `rd_en` for one cycle at a time while data is present. The overrun case runs with reads stopped, so the buffer is full and idle when the third frame ends.

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       os_tick,
  input  logic       dbl_speed,
  input  logic [2:0] len_sel,
  input  logic [1:0] par_mode,
  input  logic       filt_en,
  input  logic       rd_en,
  output logic       rx_valid,
  output logic [8:0] rx_data,
  output logic       rx_ferr,
  output logic       rx_perr,
  output logic       rx_ovr
);
  localparam int CW = $clog2(OSR);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST_N = CW'(OSR - 1);
  localparam logic [CW-1:0] LAST_D = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] MID_N  = CW'(OSR / 2);
  localparam logic [CW-1:0] MID_D  = CW'(OSR / 4);
  localparam logic [PW-1:0] PTR_TOP = PW'(DEPTH - 1);
  localparam logic [NW-1:0] FULL_N  = NW'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic          rx_m, rx_s, armed;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    idx, c_nb;
  logic [8:0]    sh;
  logic          pbit, sa, sb;
  logic          c_dbl, c_pen, c_podd, c_filt;

  logic [CW-1:0] last, mid;
  logic          vote, frame_done, flag, perr_now, accept, full, push, pop;

  logic [10:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] count;

  assign last       = c_dbl ? LAST_D : LAST_N;
  assign mid        = c_dbl ? MID_D : MID_N;
  assign vote       = (sa & sb) | (sa & rx_s) | (sb & rx_s);
  assign frame_done = os_tick && st == S_STOP && cnt == mid + 1'b1;
  assign flag       = (c_nb == 4'd9) ? sh[8] : vote;
  assign perr_now   = c_pen && ((^sh ^ pbit) != c_podd);
  assign accept     = !c_filt || flag;
  assign full       = count == FULL_N;
  assign push       = frame_done && accept && !full;
  assign pop        = rd_en && count != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      armed  <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      sa     <= 1'b1;
      sb     <= 1'b1;
      c_dbl  <= 1'b0;
      c_nb   <= 4'd8;
      c_pen  <= 1'b0;
      c_podd <= 1'b0;
      c_filt <= 1'b0;
    end else if (os_tick) begin
      if (st == S_IDLE) begin
        if (rx_s) begin
          armed <= 1'b1;
        end else if (armed) begin
          st     <= S_START;
          cnt    <= CW'(1);
          idx    <= '0;
          sh     <= '0;
          pbit   <= 1'b0;
          c_dbl  <= dbl_speed;
          c_nb   <= len_sel[2] ? 4'd9 : {2'b00, len_sel[1:0]} + 4'd5;
          c_pen  <= par_mode[1];
          c_podd <= par_mode[0];
          c_filt <= filt_en;
        end
      end else begin
        cnt <= (cnt == last) ? '0 : cnt + 1'b1;
        if (cnt == mid - 1'b1) sa <= rx_s;
        if (cnt == mid) sb <= rx_s;
        case (st)
          S_START: begin
            if (cnt == mid + 1'b1 && vote) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else if (cnt == last) begin
              st <= S_DATA;
            end
          end
          S_DATA: begin
            if (cnt == mid + 1'b1) sh[idx] <= vote;
            if (cnt == last) begin
              if (idx == c_nb - 4'd1) st <= c_pen ? S_PAR : S_STOP;
              else idx <= idx + 4'd1;
            end
          end
          S_PAR: begin
            if (cnt == mid + 1'b1) pbit <= vote;
            if (cnt == last) st <= S_STOP;
          end
          S_STOP: begin
            if (cnt == mid + 1'b1) begin
              st    <= S_IDLE;
              cnt   <= '0;
              armed <= 1'b0;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
      rx_ovr <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= {perr_now, !vote, sh};
        wp      <= (wp == PTR_TOP) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PTR_TOP) ? '0 : rp + 1'b1;
      count <= count + NW'(push) - NW'(pop);
      if (frame_done && accept && full) rx_ovr <= 1'b1;
      else if (pop) rx_ovr <= 1'b0;
    end
  end

  assign rx_valid = count != '0;
  assign {rx_perr, rx_ferr, rx_data} = mem[rp];

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= FULL_N); // R11
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) (frame_done && accept && full) |=> rx_ovr); // R11
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rd_en) |=> (rx_valid && $stable(rx_data))); // R11
  AST_DROP_DATA: assert property (@(posedge clk) disable iff (!rst_n) (frame_done && c_filt && !flag) |=> (count <= $past(count))); // R8
  AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (frame_done && flag && !full) |=> rx_valid); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (st != S_IDLE) |=> (st == S_IDLE || $stable(c_filt))); // R12
endmodule

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       os_tick = 1'b0;
  logic       dbl_speed = 1'b0;
  logic [2:0] len_sel = 3'd3;
  logic [1:0] par_mode = 2'd0;
  logic       filt_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       rx_valid, rx_ferr, rx_perr, rx_ovr;
  logic [8:0] rx_data;

  int checks = 0;
  int fails = 0;
  bit mon_on = 1'b1;
  bit done = 1'b0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  uart_addr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
    .dbl_speed(dbl_speed), .len_sel(len_sel), .par_mode(par_mode),
    .filt_en(filt_en), .rd_en(rd_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr));

  always #5 clk = ~clk;

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      os_tick = (k % 4 == 0);
      k++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rd_en) rd_en = 1'b0;
      else if (mon_on && rx_valid) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected frame", {21'd0, rx_perr, rx_ferr, rx_data}, 32'h7FF);
        end else begin
          check(tag_q[0], {21'd0, rx_perr, rx_ferr, rx_data}, {21'd0, exp_q[0]});
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
        rd_en = 1'b1;
      end
    end
  end

  task automatic drive_bit(input logic v, input int len, input bit glitch);
    for (int i = 0; i < len; i++) begin
      rx_in = (glitch && i >= len / 2 - 2 && i < len / 2 + 2) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic expect_frame(input string tag, input logic [8:0] d, input int nb,
                              input int pm, input bit bad, input logic stopv);
    logic [8:0] m = d & 9'((1 << nb) - 1);
    logic flag = (nb == 9) ? d[8] : stopv;
    if (!filt_en || flag) begin
      exp_q.push_back({(pm >= 2) && bad, ~stopv, m});
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(input logic [8:0] d, input int nb, input int pm,
                      input bit bad, input logic stopv, input bit glitch);
    int len = dbl_speed ? 32 : 64;
    logic [8:0] m = d & 9'((1 << nb) - 1);
    len_sel  = (nb == 9) ? 3'd4 : 3'(nb - 5);
    par_mode = 2'(pm);
    drive_bit(1'b0, len, 1'b0);
    for (int i = 0; i < nb; i++) drive_bit(m[i], len, glitch && i == 0);
    if (pm >= 2) drive_bit((^m) ^ (pm == 3) ^ bad, len, 1'b0);
    drive_bit(stopv, len, 1'b0);
    drive_bit(1'b1, 2 * len, 1'b0);
  endtask

  task automatic txe(input string tag, input logic [8:0] d, input int nb, input int pm,
                     input bit bad, input logic stopv, input bit glitch);
    expect_frame(tag, d, nb, pm, bad, stopv);
    send(d, nb, pm, bad, stopv, glitch);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", 32'(rx_valid), 0);
    check("R1 ovr", 32'(rx_ovr), 0);
    repeat (80) @(negedge clk);

    txe("R2 8N1 A5", 9'h0A5, 8, 0, 0, 1, 0);
    txe("R2 8N1 3C", 9'h03C, 8, 0, 0, 1, 0);
    dbl_speed = 1'b1;
    txe("R3 double 5A", 9'h05A, 8, 0, 0, 1, 0);
    txe("R3 double 9bit", 9'h1C3, 9, 0, 0, 1, 0);
    dbl_speed = 1'b0;
    drain();

    txe("R4 5bit", 9'h0FF, 5, 0, 0, 1, 0);
    txe("R4 6bit", 9'h02D, 6, 0, 0, 1, 0);
    txe("R4 7bit", 9'h055, 7, 0, 0, 1, 0);
    txe("R9 9bit b8=1", 9'h1A7, 9, 0, 0, 1, 0);
    txe("R9 9bit b8=0", 9'h0E1, 9, 0, 0, 1, 0);
    drain();

    txe("R5 even ok", 9'h0B3, 8, 2, 0, 1, 0);
    txe("R5 odd ok", 9'h0B3, 8, 3, 0, 1, 0);
    txe("R5 even bad", 9'h071, 8, 2, 1, 1, 0);
    txe("R5 odd bad 7bit", 9'h012, 7, 3, 1, 1, 0);
    drain();

    txe("R6 R7 ferr 8bit", 9'h066, 8, 0, 0, 0, 0);
    txe("R6 ferr 9bit", 9'h144, 9, 0, 0, 0, 0);
    drain();

    filt_en = 1'b1;
    txe("R10 addr 8bit", 9'h012, 8, 0, 0, 1, 0);
    txe("R8 data 8bit dropped", 9'h034, 8, 0, 0, 0, 0);
    txe("R8 data 9bit dropped", 9'h056, 9, 0, 0, 1, 0);
    txe("R10 addr 9bit", 9'h178, 9, 0, 0, 1, 0);
    dbl_speed = 1'b1;
    txe("R8 double 6bit dropped", 9'h015, 6, 0, 0, 0, 0);
    dbl_speed = 1'b0;
    drain();
    check("R8 no stray frame", 32'(exp_q.size()), 0);

    expect_frame("R12 drop despite clear", 9'h0AB, 9, 0, 0, 1);
    fork
      send(9'h0AB, 9, 0, 0, 1, 0);
      begin repeat (200) @(negedge clk); filt_en = 1'b0; end
    join
    txe("R12 accepted after clear", 9'h0CD, 9, 0, 0, 1, 0);
    expect_frame("R12 keep despite set", 9'h0EF, 9, 0, 0, 1);
    fork
      send(9'h0EF, 9, 0, 0, 1, 0);
      begin repeat (200) @(negedge clk); filt_en = 1'b1; end
    join
    filt_en = 1'b0;
    drain();

    txe("R13 glitch 1", 9'h0C1, 8, 0, 0, 1, 1);
    txe("R13 glitch 0", 9'h0C2, 8, 0, 0, 1, 1);
    rx_in = 1'b0;
    repeat (16) @(negedge clk);
    rx_in = 1'b1;
    repeat (200) @(negedge clk);
    txe("R13 after false start", 9'h081, 8, 0, 0, 1, 0);
    drain();

    mon_on = 1'b0;
    send(9'h011, 8, 0, 0, 1, 0);
    send(9'h022, 8, 0, 0, 1, 0);
    send(9'h033, 8, 0, 0, 1, 0);
    check("R11 ovr set", 32'(rx_ovr), 1);
    check("R11 head kept", 32'(rx_data), 32'h011);
    exp_q.push_back({2'b00, 9'h011});
    tag_q.push_back("R11 first kept");
    exp_q.push_back({2'b00, 9'h022});
    tag_q.push_back("R11 second kept");
    mon_on = 1'b1;
    drain();
    check("R11 ovr cleared", 32'(rx_ovr), 0);
    check("R11 third discarded", 32'(rx_valid), 0);
    check("R11 queue empty", 32'(exp_q.size()), 0);
    finish_up();
  end
endmodule